// File: doc/BRIEF.md
# GPIO Edge Timestamp Capture Unit

This block timestamps transitions on a group of general-purpose inputs. Each input is asynchronous to the block clock. It passes through a two-flop synchronizer and then a minimum-width qualifier, so that a pulse narrower than the configured hold time is rejected as a glitch. When a qualified rising or falling transition is found, the block copies a free-running time value, taken from an input bus, into a register kept for that channel and that direction. In the same cycle it raises a one-cycle event toward an interrupt-status block.

Software can also force a capture with a per-channel strobe. A forced capture travels down the rising-edge path: it stores the time value in the rising register and raises the rising event, exactly as a real rising edge would. A new capture replaces the value held before it. After reset the block first loads the synchronized input levels without reporting them, so an input that is already high does not appear as an edge.

Top module: `edge_stamp_unit`

## Requirements
- R1: There are NUM_CH channels (default 8). Each channel has its own rising and falling stamp register and its own rising and falling event bit. Channel c occupies bits [c*TIME_W +: TIME_W] of each stamp bus and bit c of each event bus.
- R2: A level change on gpio_i[c] is recognized once the synchronized level has differed from the qualified level for MIN_HOLD consecutive clock edges. The matching event is high for exactly one cycle. It is seen after the (MIN_HOLD+3)-th rising clock edge, counting the first edge that samples the new level.
- R3: A pulse on gpio_i[c] that lasts MIN_HOLD-1 cycles produces no event on either event bus and changes no stamp register.
- R4: The stored stamp equals the time_i value present just before the clock edge that raises the event.
- R5: A qualified rising transition affects only rise_evt_o[c] and the rising stamp of channel c. A qualified falling transition affects only fall_evt_o[c] and the falling stamp of channel c. Other channels are unchanged.
- R6: man_cap_i[c] high for one cycle makes rise_evt_o[c] high after the next clock edge and stores time_i in the rising stamp of channel c. Falling stamps are unchanged. Several bits may be strobed together.
- R7: A later capture overwrites the earlier value in the same register. A register changes only in a cycle in which its event bit is high.
- R8: Reset (rst_ni low, asynchronous) clears every stamp and event. For the first three clock edges after reset the synchronized levels are adopted without an event, so an input held high through reset produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpio_i | input | NUM_CH | Asynchronous capture inputs |
| man_cap_i | input | NUM_CH | Per-channel forced-capture strobe (rising path) |
| time_i | input | TIME_W | Free-running time value to be stamped |
| rise_evt_o | output | NUM_CH | One-cycle rising capture events |
| fall_evt_o | output | NUM_CH | One-cycle falling capture events |
| rise_stamp_o | output | NUM_CH*TIME_W | Rising stamps, channel c at [c*TIME_W +: TIME_W] |
| fall_stamp_o | output | NUM_CH*TIME_W | Falling stamps, channel c at [c*TIME_W +: TIME_W] |

## Verification
A pin transition is due MIN_HOLD+3 clock edges after the first edge that samples it: two synchronizer edges, MIN_HOLD qualifier edges and one capture edge. A forced capture is due one edge after its strobe. The bench changes inputs just after a falling edge. It samples one cycle before the due edge, to confirm nothing arrives early, at the due edge, and one cycle after, to confirm a single pulse. The time bus advances by a fixed step at every falling edge, so each expected stamp is the value read at stimulus time plus that step times the latency.

// File: rtl/es_pkg.sv
package es_pkg;
    localparam int unsigned DEF_NUM_CH   = 8;
    localparam int unsigned DEF_TIME_W   = 64;
    localparam int unsigned DEF_MIN_HOLD = 6;
    localparam int unsigned PRIME_EDGES  = 3;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_kind_e;
endpackage

// File: rtl/es_sync.sv
module es_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/es_qualifier.sv
module es_qualifier
    import es_pkg::*;
#(
    parameter int unsigned MIN_HOLD = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       primed_i,
    input  logic       sync_i,
    output edge_kind_e edge_o
);
    localparam int unsigned CW = $clog2(MIN_HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
        edge_kind_e    kind;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = EDGE_NONE;
        if (!primed_i) begin
            st_d.level = sync_i;
            st_d.cnt   = '0;
        end else if (sync_i != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = sync_i;
                st_d.cnt   = '0;
                st_d.kind  = sync_i ? EDGE_RISE : EDGE_FALL;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{level: 1'b0, cnt: '0, kind: EDGE_NONE};
        else         st_q <= st_d;
    end

    assign edge_o = st_q.kind;
endmodule

// File: rtl/es_capture.sv
module es_capture #(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rise_hit_i,
    input  logic              fall_hit_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              rise_evt_o,
    output logic              fall_evt_o,
    output logic [TIME_W-1:0] rise_stamp_o,
    output logic [TIME_W-1:0] fall_stamp_o
);
    typedef struct packed {
        logic              rise_evt;
        logic              fall_evt;
        logic [TIME_W-1:0] rise_stamp;
        logic [TIME_W-1:0] fall_stamp;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rise_evt = rise_hit_i;
        st_d.fall_evt = fall_hit_i;
        if (rise_hit_i) st_d.rise_stamp = time_i;
        if (fall_hit_i) st_d.fall_stamp = time_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_evt_o   = st_q.rise_evt;
    assign fall_evt_o   = st_q.fall_evt;
    assign rise_stamp_o = st_q.rise_stamp;
    assign fall_stamp_o = st_q.fall_stamp;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
    import es_pkg::*;
#(
    parameter int unsigned NUM_CH   = DEF_NUM_CH,
    parameter int unsigned TIME_W   = DEF_TIME_W,
    parameter int unsigned MIN_HOLD = DEF_MIN_HOLD
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH-1:0]        gpio_i,
    input  logic [NUM_CH-1:0]        man_cap_i,
    input  logic [TIME_W-1:0]        time_i,
    output logic [NUM_CH-1:0]        rise_evt_o,
    output logic [NUM_CH-1:0]        fall_evt_o,
    output logic [NUM_CH*TIME_W-1:0] rise_stamp_o,
    output logic [NUM_CH*TIME_W-1:0] fall_stamp_o
);
    localparam int unsigned PW = $clog2(PRIME_EDGES + 1);
    localparam logic [PW-1:0] PRIME_DONE = PW'(PRIME_EDGES);

    typedef struct packed {
        logic [PW-1:0] prime_cnt;
    } top_t;

    top_t st_d, st_q;
    logic primed;

    always_comb begin
        st_d = st_q;
        if (st_q.prime_cnt != PRIME_DONE) st_d.prime_cnt = st_q.prime_cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign primed = (st_q.prime_cnt == PRIME_DONE);

    logic [NUM_CH-1:0] sync_lvl;
    logic [NUM_CH-1:0] qual_rise;
    logic [NUM_CH-1:0] qual_fall;

    es_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(gpio_i),
        .sync_o (sync_lvl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        edge_kind_e kind;

        es_qualifier #(.MIN_HOLD(MIN_HOLD)) u_qual (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .primed_i(primed),
            .sync_i  (sync_lvl[c]),
            .edge_o  (kind)
        );

        assign qual_rise[c] = (kind == EDGE_RISE);
        assign qual_fall[c] = (kind == EDGE_FALL);

        es_capture #(.TIME_W(TIME_W)) u_cap (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .rise_hit_i  (qual_rise[c] | man_cap_i[c]),
            .fall_hit_i  (qual_fall[c]),
            .time_i      (time_i),
            .rise_evt_o  (rise_evt_o[c]),
            .fall_evt_o  (fall_evt_o[c]),
            .rise_stamp_o(rise_stamp_o[c*TIME_W +: TIME_W]),
            .fall_stamp_o(fall_stamp_o[c*TIME_W +: TIME_W])
        );
    end
endmodule

// File: rtl/es_checker.sv
module es_checker #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned TIME_W = 64
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_CH-1:0]        man_cap_i,
    input logic [TIME_W-1:0]        time_i,
    input logic [NUM_CH-1:0]        rise_evt_o,
    input logic [NUM_CH-1:0]        fall_evt_o,
    input logic [NUM_CH*TIME_W-1:0] rise_stamp_o,
    input logic [NUM_CH*TIME_W-1:0] fall_stamp_o,
    input logic [NUM_CH-1:0]        q_rise,
    input logic [NUM_CH-1:0]        q_fall
);
    logic [2:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q < 3'd4) |-> (q_rise == '0 && q_fall == '0)); // R8

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_RISE_STAMP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_evt_o[c] |-> (rise_stamp_o[c*TIME_W +: TIME_W] == $past(time_i))); // R4
        AST_FALL_STAMP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fall_evt_o[c] |-> (fall_stamp_o[c*TIME_W +: TIME_W] == $past(time_i))); // R4
        AST_RISE_STAMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !rise_evt_o[c] |-> $stable(rise_stamp_o[c*TIME_W +: TIME_W])); // R7
        AST_FALL_STAMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !fall_evt_o[c] |-> $stable(fall_stamp_o[c*TIME_W +: TIME_W])); // R7
        AST_MANUAL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            man_cap_i[c] |=> rise_evt_o[c]); // R6
        AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_evt_o[c] |-> $past(q_rise[c] | man_cap_i[c])); // R5
        AST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fall_evt_o[c] |-> $past(q_fall[c])); // R5
        AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fall_evt_o[c] |=> !fall_evt_o[c]); // R2
    end
endmodule

bind edge_stamp_unit es_checker #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .man_cap_i   (man_cap_i),
    .time_i      (time_i),
    .rise_evt_o  (rise_evt_o),
    .fall_evt_o  (fall_evt_o),
    .rise_stamp_o(rise_stamp_o),
    .fall_stamp_o(fall_stamp_o),
    .q_rise      (qual_rise),
    .q_fall      (qual_fall)
);

// File: tb/edge_stamp_unit_test.sv
module edge_stamp_unit_test;
    localparam int NC   = 8;
    localparam int TW   = 64;
    localparam int HOLD = 6;
    localparam logic [TW-1:0] STEP = 64'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     gpio = '0;
    logic [NC-1:0]     man = '0;
    logic [TW-1:0]     time_v = 64'h8000_0000_F000_0000;
    logic [NC-1:0]     rise_evt, fall_evt;
    logic [NC*TW-1:0]  rise_st, fall_st;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    edge_stamp_unit #(.NUM_CH(NC), .TIME_W(TW), .MIN_HOLD(HOLD)) uut (
        .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .man_cap_i(man), .time_i(time_v),
        .rise_evt_o(rise_evt), .fall_evt_o(fall_evt),
        .rise_stamp_o(rise_st), .fall_stamp_o(fall_st)
    );

    initial forever #4 clk = ~clk;
    initial forever begin
        @(negedge clk);
        time_v = time_v + STEP;
    end

    function automatic logic [TW-1:0] rs(int c); return rise_st[c*TW +: TW]; endfunction
    function automatic logic [TW-1:0] fs(int c); return fall_st[c*TW +: TW]; endfunction

    task automatic chk(input bit ok, input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // drive a level and check the event timing and stamp
    task automatic edge_check(input int ch, input logic lvl);
        logic [NC*TW-1:0] r0, f0;
        logic [TW-1:0] v0, exp_t;
        tick();
        gpio[ch] = lvl;
        v0 = time_v;
        r0 = rise_st; f0 = fall_st;
        exp_t = v0 + STEP * (HOLD + 2);
        repeat (HOLD + 2) @(posedge clk);
        @(negedge clk); #1;
        chk(rise_evt == '0 && fall_evt == '0, "R2 no early event", {48'd0, rise_evt, fall_evt}, 64'd0);
        tick();
        if (lvl) begin
            chk(rise_evt == NC'(1 << ch) && fall_evt == '0, "R5 rise event only", {56'd0, rise_evt}, 64'(1 << ch));
            chk(rs(ch) == exp_t, "R4 rise stamp", rs(ch), exp_t);
            chk(fall_st == f0, "R5 fall stamps kept", 64'(fall_st != f0), 64'd0);
        end else begin
            chk(fall_evt == NC'(1 << ch) && rise_evt == '0, "R5 fall event only", {56'd0, fall_evt}, 64'(1 << ch));
            chk(fs(ch) == exp_t, "R4 fall stamp", fs(ch), exp_t);
            chk(rise_st == r0, "R5 rise stamps kept", 64'(rise_st != r0), 64'd0);
        end
        for (int o = 0; o < NC; o++)
            if (o != ch)
                chk(rs(o) == r0[o*TW +: TW] && fs(o) == f0[o*TW +: TW], "R5 other channel kept", rs(o), r0[o*TW +: TW]);
        tick();
        chk(rise_evt == '0 && fall_evt == '0, "R2 single pulse", {48'd0, rise_evt, fall_evt}, 64'd0);
    endtask

    // pulse of width w cycles, counts events over a window
    task automatic pulse_check(input int ch, input int w);
        logic [NC*TW-1:0] r0, f0;
        logic [TW-1:0] v0, v1;
        int nr, nf;
        nr = 0; nf = 0;
        tick();
        r0 = rise_st; f0 = fall_st;
        gpio[ch] = 1'b1;
        v0 = time_v;
        for (int i = 0; i < w; i++) begin
            tick();
            nr += $countones(rise_evt); nf += $countones(fall_evt);
        end
        gpio[ch] = 1'b0;
        v1 = time_v;
        for (int i = 0; i < 2 * HOLD + 8; i++) begin
            tick();
            nr += $countones(rise_evt); nf += $countones(fall_evt);
        end
        if (w < HOLD) begin
            chk(nr == 0 && nf == 0, "R3 glitch ignored", 64'(nr + nf), 64'd0);
            chk(rise_st == r0 && fall_st == f0, "R3 stamps unchanged", 64'(rs(ch)), r0[ch*TW +: TW]);
        end else begin
            chk(nr == 1 && nf == 1, "R2 minimum pulse accepted", 64'(nr * 16 + nf), 64'h11);
            chk(rs(ch) == v0 + STEP * (HOLD + 2), "R4 pulse rise stamp", rs(ch), v0 + STEP * (HOLD + 2));
            chk(fs(ch) == v1 + STEP * (HOLD + 2), "R4 pulse fall stamp", fs(ch), v1 + STEP * (HOLD + 2));
        end
    endtask

    task automatic manual_check(input logic [NC-1:0] mask);
        logic [NC*TW-1:0] r0, f0;
        logic [TW-1:0] v0;
        tick();
        r0 = rise_st; f0 = fall_st;
        man = mask;
        v0 = time_v;
        tick();
        man = '0;
        chk(rise_evt == mask && fall_evt == '0, "R6 manual event", {56'd0, rise_evt}, {56'd0, mask});
        for (int c = 0; c < NC; c++) begin
            if (mask[c]) chk(rs(c) == v0, "R6 manual stamp", rs(c), v0);
            else         chk(rs(c) == r0[c*TW +: TW], "R6 unselected kept", rs(c), r0[c*TW +: TW]);
        end
        chk(fall_st == f0, "R6 fall stamps kept", 64'(fall_st != f0), 64'd0);
        tick();
        chk(rise_evt == '0, "R6 manual single pulse", {56'd0, rise_evt}, 64'd0);
    endtask

    task automatic quiet_after_reset(input logic [NC-1:0] lv);
        int n;
        n = 0;
        gpio = lv;
        rst_n = 1'b0;
        repeat (3) tick();
        chk(rise_evt == '0 && fall_evt == '0, "R8 reset events", {48'd0, rise_evt, fall_evt}, 64'd0);
        chk(rise_st == '0 && fall_st == '0, "R8 reset stamps", 64'(rise_st != '0 || fall_st != '0), 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 3 * HOLD; i++) begin
            tick();
            n += $countones(rise_evt) + $countones(fall_evt);
        end
        chk(n == 0, "R8 held level quiet", 64'(n), 64'd0);
    endtask

    initial begin
        quiet_after_reset(8'h81);
        edge_check(0, 1'b0);
        edge_check(7, 1'b0);
        for (int c = 0; c < NC; c++) begin
            pulse_check(c, HOLD - 1);
            pulse_check(c, HOLD);
            edge_check(c, 1'b1);
            edge_check(c, 1'b0);
        end
        begin : overwrite_r7
            logic [TW-1:0] first;
            edge_check(3, 1'b1);
            first = rs(3);
            edge_check(3, 1'b0);
            edge_check(3, 1'b1);
            chk(rs(3) != first, "R7 overwrite", rs(3), first + 64'd1);
        end
        edge_check(3, 1'b0);
        for (int c = 0; c < NC; c++) manual_check(NC'(1 << c));
        manual_check(8'hA5);
        manual_check(8'h5A);
        manual_check(8'hFF);
        chk(rise_evt == '0 && fall_evt == '0 && rs(0) != '0, "R1 stamps populated", rs(0), 64'd1);
        quiet_after_reset(8'h3C);
        edge_check(2, 1'b0);
        edge_check(6, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule